// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a list of scatter-gather segments into a descriptor table for a bus-mastering disk DMA engine. Each segment arrives as a 32-bit bus address and a 32-bit byte length on a valid/ready stream. A flag marks the final segment of a list. The block cuts every segment into pieces so that no piece crosses a 64 KB address boundary. It writes each piece as a pair of 32-bit words into a table memory through a plain write port, one word per clock.

When the list ends, the block pulses `done` for one cycle. With the pulse it gives either the number of entries built or the reason the build failed. A failure means the table is too small or the table is empty, and the caller then moves the data with programmed I/O instead.

A mode input picks between two count formats:
- **Standard format:** a full 64 KB piece is split into two 32 KB entries, because some controllers read a zero count as zero bytes. The last entry carries an end-of-table flag, which is written by going back over that word once the list has ended.
- **Alternate format:** the count field is stored in the upper half of the count word, and no end flag is written.

Top module: `sg_desc_gen`

## Requirements
- R1: Each segment is cut into pieces whose length is the smaller of the bytes left in the segment and the distance to the next 64 KB address boundary (0x10000 minus the low 16 address bits). On success, `entryCount` equals the number of entries produced.
- R2: Entry k occupies table word 2k (the piece's bus address) and word 2k+1 (its count word). Entries are numbered from 0 in the order the pieces are produced.
- R3: In standard mode (`altMode`=0), the count word is the piece length in bits 15:0, with the upper bits zero. A piece of exactly 0x10000 bytes is emitted as two entries, {addr, 0x8000} and {addr+0x8000, 0x8000}.
- R4: In standard mode, after the last segment, bit 31 of the final entry's count word is set by rewriting that word. In alternate mode no bit 31 is added.
- R5: In alternate mode, the count word is ((length >> 2) − 1) placed in bits 31:16, with bits 15:0 zero.
- R6: At most MAX_ENTRIES entries are written. If a list needs more, including through the second half of a 64 KB split, the following happens:
  - `tooSmall` is set at `done`, with `okay`=0 and `entryCount`=0.
  - Exactly 2·MAX_ENTRIES words are written.
  - The remaining segments of the list are consumed, and no further words are written.
- R7: A list that produces no entries (for example, only zero-length segments) ends with `emptyTable`=1, `okay`=0 and `entryCount`=0. A zero-length segment produces no entry.
- R8: `alignErr` is set at `done` if any segment of the list is misaligned. In standard mode that means an odd address or an odd length. In alternate mode that means an address or a length that is not a multiple of 4. The table is still built.
- R9: Words are written one per clock. The total number of writes for a successful list is 2·entries, plus 1 in standard mode for the end-flag rewrite. `segReady` is low while a segment is being split and while any word is written.
- R10: After reset, `segReady`=1, `done`=0 and `wrEn`=0.
- R11: `done` is a single-cycle pulse. It is followed by a cycle with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| altMode | input | 1 | 1 selects the alternate count format; sampled with the first segment of a list |
| segValid | input | 1 | Segment offered |
| segReady | output | 1 | Segment accepted when high with segValid |
| segAddr | input | 32 | Segment bus address |
| segLen | input | 32 | Segment length in bytes |
| segLast | input | 1 | Segment is the final one of its list |
| wrEn | output | 1 | Table word write strobe |
| wrAddr | output | ADDR_W | Table word index |
| wrData | output | 32 | Table word value |
| done | output | 1 | One-cycle end-of-list pulse |
| okay | output | 1 | Build succeeded (valid with done) |
| entryCount | output | CNT_W | Entries built, 0 on failure (valid with done) |
| tooSmall | output | 1 | Entry limit exceeded (valid with done) |
| emptyTable | output | 1 | No entries produced (valid with done) |
| alignErr | output | 1 | A segment was misaligned (valid with done) |

## Verification
The bench goes after the following corner cases:
- **Segments straddling a 64 KB boundary.** A design that miscomputes the edge would emit an entry crossing the boundary, or would produce the wrong entry count.
- **Boundary-aligned 64 KB pieces in both modes.** A wrong design would write a zero count in standard mode, or would split the piece needlessly in alternate mode.
- **A list that fills the table exactly.** A wrong design would misplace the end flag.
- **A list that overflows only on the second half of a split.** A wrong design would report success or keep writing after the limit.
- **Zero-length and empty lists, and misaligned segments arriving after an overflow.** A wrong design would report success on an empty table or lose the alignment flag.

Constrained-random lists in both modes are checked word by word against an independent model. Each check covers both the table contents and the exact number of writes.

// File: rtl/sg_desc_pkg.sv
package sg_desc_pkg;

  typedef enum logic [2:0] {
    S_ACCEPT,
    S_ADDRW,
    S_CNTW,
    S_DRAIN,
    S_FINISH
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadSeg;
    logic chkAlign;
    logic wrAddrWord;
    logic wrCntWord;
    logic fixup;
    logic markFull;
    logic clearList;
  } dpCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic inLenZero;
    logic pieceDone;
    logic full;
    logic lastSeg;
    logic alt;
    logic okay;
  } dpStat_t;

endpackage

// File: rtl/sg_desc_ctrl.sv
module sg_desc_ctrl
  import sg_desc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    segValid,
  input  logic    segLast,
  input  dpStat_t st,
  output dpCtl_t  ctl,
  output logic    segReady,
  output logic    done
);

  ctlState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_ACCEPT;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    segReady  = 1'b0;
    done      = 1'b0;
    unique case (state)
      S_ACCEPT: begin
        segReady = 1'b1;
        if (segValid) begin
          ctl.loadSeg  = 1'b1;
          ctl.chkAlign = 1'b1;
          if (st.inLenZero) nextState = segLast ? S_FINISH : S_ACCEPT;
          else              nextState = S_ADDRW;
        end
      end
      S_ADDRW: begin
        if (st.full) begin
          ctl.markFull = 1'b1;
          nextState    = st.lastSeg ? S_FINISH : S_DRAIN;
        end else begin
          ctl.wrAddrWord = 1'b1;
          nextState      = S_CNTW;
        end
      end
      S_CNTW: begin
        ctl.wrCntWord = 1'b1;
        if (st.pieceDone) nextState = st.lastSeg ? S_FINISH : S_ACCEPT;
        else              nextState = S_ADDRW;
      end
      S_DRAIN: begin
        segReady = 1'b1;
        if (segValid) begin
          ctl.chkAlign = 1'b1;
          if (segLast) nextState = S_FINISH;
        end
      end
      S_FINISH: begin
        done          = 1'b1;
        ctl.fixup     = !st.alt && st.okay;
        ctl.clearList = 1'b1;
        nextState     = S_ACCEPT;
      end
      default: nextState = S_ACCEPT;
    endcase
  end

endmodule

// File: rtl/sg_desc_dp.sv
module sg_desc_dp
  import sg_desc_pkg::*;
#(
  parameter int MAX_ENTRIES = 16,
  parameter int ADDR_W      = 5,
  parameter int CNT_W       = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              altMode,
  input  logic [31:0]       segAddr,
  input  logic [31:0]       segLen,
  input  logic              segLast,
  output dpStat_t           st,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  output logic              okay,
  output logic [CNT_W-1:0]  entryCount,
  output logic              tooSmall,
  output logic              emptyTable,
  output logic              alignErr
);

  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_ENTRIES);
  localparam logic [16:0]      SPAN64K   = 17'h10000;
  localparam logic [16:0]      SPAN32K   = 17'h08000;
  localparam logic [31:0]      END_FLAG  = 32'h8000_0000;

  logic [31:0]       curAddr, remLen, lastVal;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] lastIdx;
  logic              alignSticky, fullSticky, altReg, lastSegReg, firstSeg;

  logic [16:0]       toEdge, rawPiece, pieceLen, quarterM1;
  logic [31:0]       cntWord;
  logic [ADDR_W-1:0] addrIdx, cntIdx;
  logic              modeNow, misIn;

  // piece sizing: distance to the next 64 KB edge, capped by what is left
  always_comb begin
    toEdge    = SPAN64K - {1'b0, curAddr[15:0]};
    rawPiece  = (remLen < {15'b0, toEdge}) ? remLen[16:0] : toEdge;
    // a whole 64 KB piece in standard mode goes out as two 32 KB halves
    pieceLen  = (!altReg && rawPiece == SPAN64K) ? SPAN32K : rawPiece;
    quarterM1 = {2'b0, pieceLen[16:2]} - 17'd1;
    cntWord   = altReg ? {quarterM1[15:0], 16'h0000} : {16'h0000, pieceLen[15:0]};
    addrIdx   = {count[ADDR_W-2:0], 1'b0};
    cntIdx    = {count[ADDR_W-2:0], 1'b1};
  end

  assign modeNow = firstSeg ? altMode : altReg;
  assign misIn   = modeNow ? ((|segAddr[1:0]) | (|segLen[1:0]))
                           : (segAddr[0] | segLen[0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr     <= '0;
      remLen      <= '0;
      lastVal     <= '0;
      count       <= '0;
      lastIdx     <= '0;
      alignSticky <= 1'b0;
      fullSticky  <= 1'b0;
      altReg      <= 1'b0;
      lastSegReg  <= 1'b0;
      firstSeg    <= 1'b1;
    end else begin
      if (ctl.chkAlign) begin
        altReg   <= modeNow;
        firstSeg <= 1'b0;
        if (misIn) alignSticky <= 1'b1;
      end
      if (ctl.loadSeg) begin
        curAddr    <= segAddr;
        remLen     <= segLen;
        lastSegReg <= segLast;
      end
      if (ctl.wrCntWord) begin
        curAddr <= curAddr + {15'b0, pieceLen};
        remLen  <= remLen - {15'b0, pieceLen};
        count   <= count + CNT_ONE;
        lastIdx <= cntIdx;
        lastVal <= cntWord;
      end
      if (ctl.markFull) fullSticky <= 1'b1;
      if (ctl.clearList) begin
        count       <= '0;
        alignSticky <= 1'b0;
        fullSticky  <= 1'b0;
        firstSeg    <= 1'b1;
      end
    end
  end

  // write port
  always_comb begin
    wrEn   = ctl.wrAddrWord | ctl.wrCntWord | ctl.fixup;
    wrAddr = addrIdx;
    wrData = curAddr;
    if (ctl.wrCntWord) begin
      wrAddr = cntIdx;
      wrData = cntWord;
    end else if (ctl.fixup) begin
      wrAddr = lastIdx;
      wrData = lastVal | END_FLAG;
    end
  end

  // result
  assign okay       = (count != '0) && !fullSticky;
  assign entryCount = okay ? count : '0;
  assign tooSmall   = fullSticky;
  assign emptyTable = (count == '0) && !fullSticky;
  assign alignErr   = alignSticky;

  assign st.inLenZero = (segLen == '0);
  assign st.pieceDone = (remLen == {15'b0, pieceLen});
  assign st.full      = (count == CNT_LIMIT);
  assign st.lastSeg   = lastSegReg;
  assign st.alt       = altReg;
  assign st.okay      = okay;

endmodule

// File: rtl/sg_desc_gen.sv
module sg_desc_gen
  import sg_desc_pkg::*;
#(
  parameter int MAX_ENTRIES = 16,
  localparam int ADDR_W     = $clog2(2 * MAX_ENTRIES),
  localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              altMode,
  input  logic              segValid,
  output logic              segReady,
  input  logic [31:0]       segAddr,
  input  logic [31:0]       segLen,
  input  logic              segLast,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  output logic              done,
  output logic              okay,
  output logic [CNT_W-1:0]  entryCount,
  output logic              tooSmall,
  output logic              emptyTable,
  output logic              alignErr
);

  dpCtl_t  ctl;
  dpStat_t st;

  sg_desc_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .segValid (segValid),
    .segLast  (segLast),
    .st       (st),
    .ctl      (ctl),
    .segReady (segReady),
    .done     (done)
  );

  sg_desc_dp #(
    .MAX_ENTRIES (MAX_ENTRIES),
    .ADDR_W      (ADDR_W),
    .CNT_W       (CNT_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .altMode    (altMode),
    .segAddr    (segAddr),
    .segLen     (segLen),
    .segLast    (segLast),
    .st         (st),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .okay       (okay),
    .entryCount (entryCount),
    .tooSmall   (tooSmall),
    .emptyTable (emptyTable),
    .alignErr   (alignErr)
  );

endmodule

// File: rtl/sg_desc_chk.sv
module sg_desc_chk #(
  parameter int MAX_ENTRIES = 16,
  parameter int ADDR_W      = 5,
  parameter int CNT_W       = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              segReady,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              done,
  input logic              okay,
  input logic [CNT_W-1:0]  entryCount
);

  a_r2_index_in_table: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (int'(wrAddr) < 2 * MAX_ENTRIES));

  a_r9_no_accept_while_writing: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !segReady);

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r11_quiet_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !wrEn);

  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (done && okay) |-> (entryCount != '0 && int'(entryCount) <= MAX_ENTRIES));

endmodule

bind sg_desc_gen sg_desc_chk #(
  .MAX_ENTRIES (MAX_ENTRIES),
  .ADDR_W      (ADDR_W),
  .CNT_W       (CNT_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .segReady   (segReady),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .done       (done),
  .okay       (okay),
  .entryCount (entryCount)
);

// File: tb/sim_sg_desc_gen.sv
`timescale 1ns/1ps
module sim_sg_desc_gen;

  localparam int CLK_PERIOD = 10;
  localparam int MAXE       = 16;
  localparam int AW         = $clog2(2 * MAXE);
  localparam int CW         = $clog2(MAXE + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          altMode = 1'b0;
  logic          segValid = 1'b0;
  logic          segReady;
  logic [31:0]   segAddr = '0;
  logic [31:0]   segLen = '0;
  logic          segLast = 1'b0;
  logic          wrEn;
  logic [AW-1:0] wrAddr;
  logic [31:0]   wrData;
  logic          done, okay, tooSmall, emptyTable, alignErr;
  logic [CW-1:0] entryCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  sg_desc_gen #(.MAX_ENTRIES(MAXE)) u0 (
    .clk(clk), .rstN(rstN), .altMode(altMode),
    .segValid(segValid), .segReady(segReady),
    .segAddr(segAddr), .segLen(segLen), .segLast(segLast),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .done(done), .okay(okay), .entryCount(entryCount),
    .tooSmall(tooSmall), .emptyTable(emptyTable), .alignErr(alignErr)
  );

  int checks = 0;
  int fails  = 0;

  // table memory model and write counter
  logic [31:0] mem [0:2*MAXE-1];
  int wrCount = 0;
  always @(posedge clk) begin
    if (wrEn) begin
      mem[wrAddr] <= wrData;
      wrCount     <= wrCount + 1;
    end
  end

  // list under test
  logic [31:0] sA [0:7];
  logic [31:0] sL [0:7];
  int          nSeg;
  logic        listAlt;

  // reference results
  logic [31:0] expW [0:2*MAXE-1];
  int          expCnt;
  logic        expFull, expAlign;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic buildRef();
    logic [31:0] a, l, b, x;
    int cnt;
    cnt = 0; expFull = 1'b0; expAlign = 1'b0;
    for (int k = 0; k < 2*MAXE; k++) expW[k] = '0;
    for (int s = 0; s < nSeg; s++) begin
      if (listAlt) begin
        if ((sA[s][1:0] != 2'b00) || (sL[s][1:0] != 2'b00)) expAlign = 1'b1;
      end else begin
        if (sA[s][0] || sL[s][0]) expAlign = 1'b1;
      end
      a = sA[s]; l = sL[s];
      while (l != 0 && !expFull) begin
        if (cnt >= MAXE) begin expFull = 1'b1; break; end
        b = 32'h10000 - {16'h0, a[15:0]};
        if (b > l) b = l;
        x = listAlt ? (((b >> 2) - 32'd1) << 16) : (b & 32'hFFFF);
        expW[2*cnt] = a;
        cnt++;
        if (!listAlt && x == 0) begin
          if (cnt >= MAXE) begin expFull = 1'b1; break; end
          expW[2*cnt-1] = 32'h8000;
          expW[2*cnt]   = a + 32'h8000;
          cnt++;
          x = 32'h8000;
        end
        expW[2*cnt-1] = x;
        a = a + b;
        l = l - b;
      end
    end
    if (!expFull && cnt > 0 && !listAlt) expW[2*cnt-1] = expW[2*cnt-1] | 32'h8000_0000;
    expCnt = cnt;
  endtask

  int wd = 0;

  task automatic sendSeg(input int s);
    @(negedge clk);
    while (!segReady && wd < 100000) begin @(negedge clk); wd++; end
    segValid = 1'b1;
    segAddr  = sA[s];
    segLen   = sL[s];
    segLast  = (s == nSeg - 1);
    @(posedge clk);
    @(negedge clk);
    segValid = 1'b0;
  endtask

  task automatic runList(input string name);
    logic gOk, gSmall, gEmpty, gAlign;
    logic [CW-1:0] gCnt;
    int expWr;
    string t;
    buildRef();
    @(negedge clk);
    altMode = listAlt;
    wrCount = 0;
    for (int s = 0; s < nSeg; s++) sendSeg(s);
    while (!done && wd < 100000) begin @(negedge clk); wd++; end
    gOk = okay; gSmall = tooSmall; gEmpty = emptyTable; gAlign = alignErr; gCnt = entryCount;
    @(negedge clk);
    t = {name, " R11 done pulse"};
    check(t, {31'b0, done}, 32'd0);
    if (expFull)          expWr = 2*MAXE;
    else if (expCnt == 0) expWr = 0;
    else                  expWr = 2*expCnt + (listAlt ? 0 : 1);
    check({name, " R1 entryCount"}, {{(32-CW){1'b0}}, gCnt},
          (expFull || expCnt == 0) ? 32'd0 : expCnt);
    check({name, " R6 tooSmall"}, {31'b0, gSmall}, {31'b0, expFull});
    check({name, " R7 emptyTable"}, {31'b0, gEmpty}, {31'b0, (!expFull && expCnt == 0)});
    check({name, " R6 okay"}, {31'b0, gOk}, {31'b0, (!expFull && expCnt != 0)});
    check({name, " R8 alignErr"}, {31'b0, gAlign}, {31'b0, expAlign});
    check({name, " R9 write count"}, wrCount, expWr);
    if (!expFull) begin
      for (int k = 0; k < 2*expCnt; k++) begin
        if (k % 2 == 0)               t = {name, " R2 address word"};
        else if (listAlt)             t = {name, " R5 count word"};
        else if (k == 2*expCnt - 1)   t = {name, " R4 last count word"};
        else                          t = {name, " R3 count word"};
        check(t, mem[k], expW[k]);
      end
    end
  endtask

  function automatic logic [31:0] rndLen(input logic alt);
    logic [31:0] v;
    case ($urandom % 5)
      0: v = ($urandom % 32'h800) + 1;
      1: v = 32'h10000;
      2: v = ($urandom % 32'h30000) + 1;
      3: v = 32'h0;
      default: v = ($urandom % 32'h12000) + 1;
    endcase
    if ($urandom % 8 != 0) v = alt ? (v & ~32'h3) : (v & ~32'h1);
    return v;
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 reset segReady", {31'b0, segReady}, 32'd1);
    check("R10 reset done", {31'b0, done}, 32'd0);
    check("R10 reset wrEn", {31'b0, wrEn}, 32'd0);

    // straddling a 64 KB edge
    listAlt = 1'b0; nSeg = 1; sA[0] = 32'h0001_F000; sL[0] = 32'h3000;
    runList("edge");
    // aligned 64 KB in standard mode
    listAlt = 1'b0; nSeg = 1; sA[0] = 32'h0005_0000; sL[0] = 32'h10000;
    runList("std64k");
    // alternate mode with an unaligned start
    listAlt = 1'b1; nSeg = 1; sA[0] = 32'h0000_0100; sL[0] = 32'h10000;
    runList("altedge");
    // aligned 64 KB in alternate mode: one entry
    listAlt = 1'b1; nSeg = 1; sA[0] = 32'h0002_0000; sL[0] = 32'h10000;
    runList("alt64k");
    // exactly MAXE entries
    listAlt = 1'b0; nSeg = 1; sA[0] = 32'h0010_0000; sL[0] = 32'h80000;
    runList("exactfull");
    // overflow on the second half of a split, then a misaligned drained segment
    listAlt = 1'b0; nSeg = 4;
    sA[0] = 32'h0001_0000; sL[0] = 32'h70000;
    sA[1] = 32'h0000_1000; sL[1] = 32'h1000;
    sA[2] = 32'h0010_0000; sL[2] = 32'h10000;
    sA[3] = 32'h0000_0003; sL[3] = 32'h5;
    runList("splitovf");
    // empty list
    listAlt = 1'b0; nSeg = 2; sA[0] = 32'h1000; sL[0] = 0; sA[1] = 32'h2000; sL[1] = 0;
    runList("empty");
    // zero-length segment in the middle
    listAlt = 1'b0; nSeg = 3;
    sA[0] = 32'h4000; sL[0] = 32'h200; sA[1] = 32'h9000; sL[1] = 0;
    sA[2] = 32'h8000; sL[2] = 32'h200;
    runList("zeromid");
    // odd address in standard mode
    listAlt = 1'b0; nSeg = 1; sA[0] = 32'h0000_0101; sL[0] = 32'h100;
    runList("odd");

    for (int r = 0; r < 60; r++) begin
      listAlt = $urandom % 2;
      nSeg = ($urandom % 4) + 1;
      for (int s = 0; s < nSeg; s++) begin
        sA[s] = $urandom;
        if ($urandom % 4 == 0) sA[s][15:0] = 16'h0000;
        if ($urandom % 8 != 0) sA[s] = listAlt ? (sA[s] & ~32'h3) : (sA[s] & ~32'h1);
        sL[s] = rndLen(listAlt);
      end
      runList("random");
    end

    if (wd >= 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: got hung expected done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule